// File: doc/BRIEF.md
# SDRAM power-up and refresh sequencer

This block drives the command pins of a single-data-rate SDRAM from power-up into normal operation, and then keeps the array refreshed. After reset it holds the device deselected for a long pause. It then plays a fixed command script: one NOP, a precharge of all banks, eight auto-refresh commands and a load of the mode register. The script uses CAS latency 3 and a burst of one word. Each command is followed by the number of clock cycles the device needs before the next one. All waits are parameters counted in clock cycles. The defaults assume a 100 MHz clock and a part with 16-bit data, two banks, 11 row bits and 8 column bits.

Once the mode load has settled, `init_done` rises and a refresh interval timer starts. When the interval expires, the block raises `ref_req` toward the memory arbiter. The arbiter grants the slot by asserting `ref_ack`, which acts as the ready of a one-beat valid/ready transfer. `ref_req` is the valid and stays high until the cycle in which both are high. Holding `ref_ack` low is back-pressure: the request simply waits. On the grant, the block issues a precharge-all, waits, then issues an auto-refresh. The interval timer reloads from `ref_interval` at that auto-refresh.

The interval comes from a software-programmable register outside this block. Its value must be at least `T_RFC`, so that a new request never overlaps a refresh still in progress.

Top module: `sdram_init_refresh`

## Requirements
- R1: While reset is asserted, the command pins {cs_n,ras_n,cas_n,we_n} read 1111 (deselect), `addr` and `ba` are 0, and `init_done` and `ref_req` are low.
- R2: The pins stay at deselect 1111 until the PWRUP_CYC-th rising edge after reset release. From that edge on, the first command, a NOP (0111), is on the pins.
- R3: During initialization exactly these commands appear, in this order: NOP, precharge-all, INIT_REFS (8) auto-refreshes, one mode load. A mode load never appears once `init_done` is high.
- R4: The precharge-all follows the NOP by one cycle. The next command follows a precharge by exactly T_RP cycles and an initialization auto-refresh by exactly T_RFC cycles. Every cycle between commands carries NOP 0111.
- R5: A precharge is encoded 0010 with address bit 10 high and all other address bits and `ba` at 0.
- R6: An auto-refresh is encoded 0001. A mode load is encoded 0000 with `ba` = 0 and `addr` = CAS_LAT in bits 6:4, all other bits 0 (bits 2:0 = 0 select a burst of one, bit 3 = 0 selects sequential order).
- R7: `init_done` rises exactly T_MRD cycles after the mode load appears and stays high until reset.
- R8: `ref_req` is low before `init_done`. It rises exactly `ref_interval` cycles after `init_done` rises, and after that exactly `ref_interval` cycles after each refresh auto-refresh command.
- R9: `ref_req` stays high until a rising edge at which `ref_ack` is also high, and it is low in the cycle after that edge.
- R10: After such a handshake the precharge-all is on the pins in the next cycle, and the auto-refresh follows exactly T_RP cycles later.
- R11: `ref_interval` is sampled only at the edge that brings `init_done` up or issues a refresh auto-refresh. Changes at any other time leave the running interval unaffected.
- R12: `ref_ack` while `ref_req` is low has no effect: no command is issued and the next request keeps its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_interval | input | IVL_W | Refresh interval in cycles, at least T_RFC |
| ref_ack | input | 1 | Arbiter grant (ready) for a refresh request |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Initialization complete |
| ref_req | output | 1 | Refresh request (valid) |

## Verification
The bench builds the block with PWRUP_CYC = 60 and keeps every other timing at its default. Shortening the pause brings the whole initialization script and about thirty refresh handshakes into a short run. The refresh interval is redrawn at random between T_RFC and 60. That range reaches the tightest legal case, where a request rises in the very cycle the previous refresh wait ends. Grant delays of zero to seven cycles, and stray grants while no request is pending, exercise back-pressure and the rule that stray grants are ignored.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LOAD_MODE = 4'b0000,
    CMD_AUTO_REF  = 4'b0001,
    CMD_PRECHARGE = 4'b0010,
    CMD_NOP       = 4'b0111,
    CMD_DESELECT  = 4'b1111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWRUP, ST_NOP, ST_PRE, ST_IREF, ST_MRS, ST_IDLE, ST_RPRE, ST_RREF
  } seq_state_e;
endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= CNT_W'(RST_VAL);
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IVL_W-1:0] interval,
  input  logic             clear,
  output logic             req
);
  logic [IVL_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
      req   <= 1'b0;
    end else if (load) begin
      cnt   <= interval - 1'b1;
      armed <= 1'b1;
      req   <= 1'b0;
    end else begin
      if (clear) req <= 1'b0;
      if (armed) begin
        if (cnt == '0) begin
          req   <= 1'b1;
          armed <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm
  import sdram_seq_pkg::*;
#(
  parameter int T_RP      = 5,
  parameter int T_RFC     = 13,
  parameter int T_MRD     = 2,
  parameter int INIT_REFS = 8,
  parameter int CAS_LAT   = 3,
  parameter int ADDR_W    = 11,
  parameter int BA_W      = 1,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  input  logic              ref_req,
  input  logic              ref_ack,
  output logic              ref_load,
  output logic              ref_clear,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam int REF_W = $clog2(INIT_REFS + 1);
  localparam int AP_BIT = 10;
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(CAS_LAT << 4);
  localparam logic [ADDR_W-1:0] AP_WORD   = ADDR_W'(1) << AP_BIT;

  seq_state_e state, nxt;
  logic [REF_W-1:0] nref;
  logic do_issue, is_pre, is_mrs, ref_inc, set_done;
  sd_cmd_e issue_cmd;
  sd_cmd_e cmd_q;

  always_comb begin
    nxt = state; do_issue = 1'b0; issue_cmd = CMD_NOP;
    is_pre = 1'b0; is_mrs = 1'b0; ref_inc = 1'b0; set_done = 1'b0;
    tmr_load = 1'b0; tmr_val = '0; ref_load = 1'b0; ref_clear = 1'b0;
    case (state)
      ST_PWRUP: if (tmr_expired) begin
        do_issue = 1'b1; issue_cmd = CMD_NOP; tmr_load = 1'b1; nxt = ST_NOP;
      end
      ST_NOP: if (tmr_expired) begin
        do_issue = 1'b1; issue_cmd = CMD_PRECHARGE; is_pre = 1'b1;
        tmr_load = 1'b1; tmr_val = CNT_W'(T_RP - 1); nxt = ST_PRE;
      end
      ST_PRE: if (tmr_expired) begin
        do_issue = 1'b1; issue_cmd = CMD_AUTO_REF; ref_inc = 1'b1;
        tmr_load = 1'b1; tmr_val = CNT_W'(T_RFC - 1); nxt = ST_IREF;
      end
      ST_IREF: if (tmr_expired) begin
        do_issue = 1'b1; tmr_load = 1'b1;
        if (nref == REF_W'(INIT_REFS)) begin
          issue_cmd = CMD_LOAD_MODE; is_mrs = 1'b1;
          tmr_val = CNT_W'(T_MRD - 1); nxt = ST_MRS;
        end else begin
          issue_cmd = CMD_AUTO_REF; ref_inc = 1'b1;
          tmr_val = CNT_W'(T_RFC - 1);
        end
      end
      ST_MRS: if (tmr_expired) begin
        set_done = 1'b1; ref_load = 1'b1; nxt = ST_IDLE;
      end
      ST_IDLE: if (ref_req && ref_ack) begin
        ref_clear = 1'b1; do_issue = 1'b1; issue_cmd = CMD_PRECHARGE; is_pre = 1'b1;
        tmr_load = 1'b1; tmr_val = CNT_W'(T_RP - 1); nxt = ST_RPRE;
      end
      ST_RPRE: if (tmr_expired) begin
        do_issue = 1'b1; issue_cmd = CMD_AUTO_REF; ref_load = 1'b1;
        tmr_load = 1'b1; tmr_val = CNT_W'(T_RFC - 1); nxt = ST_RREF;
      end
      ST_RREF: if (tmr_expired) nxt = ST_IDLE;
      default: nxt = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_PWRUP;
      nref   <= '0;
      cmd_q  <= CMD_DESELECT;
      addr_o <= '0;
      done_o <= 1'b0;
    end else begin
      state <= nxt;
      if (ref_inc)  nref <= nref + 1'b1;
      if (set_done) done_o <= 1'b1;
      if (do_issue)               cmd_q <= issue_cmd;
      else if (state == ST_PWRUP) cmd_q <= CMD_DESELECT;
      else                        cmd_q <= CMD_NOP;
      addr_o <= is_pre ? AP_WORD : (is_mrs ? MODE_WORD : '0);
    end
  end

  assign cmd_o = cmd_q;
  assign ba_o  = '0;
endmodule

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh #(
  parameter int PWRUP_CYC = 20000,
  parameter int T_RP      = 5,
  parameter int T_RFC     = 13,
  parameter int T_MRD     = 2,
  parameter int INIT_REFS = 8,
  parameter int CAS_LAT   = 3,
  parameter int ADDR_W    = 11,
  parameter int BA_W      = 1,
  parameter int IVL_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IVL_W-1:0]  ref_interval,
  input  logic              ref_ack,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              ref_req
);
  localparam int MAX_WAIT = (PWRUP_CYC > T_RFC) ? PWRUP_CYC : T_RFC;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic             tmr_expired, tmr_load, ref_load, ref_clear;
  logic [CNT_W-1:0] tmr_val;
  logic [3:0]       cmd;

  sdram_wait_timer #(.CNT_W(CNT_W), .RST_VAL(PWRUP_CYC - 1)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired));

  sdram_refresh_timer #(.IVL_W(IVL_W)) u_rtmr (
    .clk(clk), .rst_n(rst_n), .load(ref_load), .interval(ref_interval),
    .clear(ref_clear), .req(ref_req));

  sdram_cmd_fsm #(
    .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .INIT_REFS(INIT_REFS),
    .CAS_LAT(CAS_LAT), .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .tmr_expired(tmr_expired), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .ref_req(ref_req), .ref_ack(ref_ack),
    .ref_load(ref_load), .ref_clear(ref_clear), .cmd_o(cmd), .ba_o(ba),
    .addr_o(addr), .done_o(init_done));

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
endmodule

// File: rtl/sdram_init_refresh_chk.sv
module sdram_init_refresh_chk #(
  parameter int ADDR_W  = 11,
  parameter int BA_W    = 1,
  parameter int CAS_LAT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              init_done,
  input logic              ref_req,
  input logic              ref_ack
);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(CAS_LAT << 4);

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R7
  AST_NO_REQ_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ref_req); // R8
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> ref_req); // R9
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> addr[10]); // R5
  AST_MODE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |-> (addr == MODE_WORD && ba == '0)); // R6
  AST_PRE_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |=> (cmd == 4'b0111)); // R4
  AST_NO_LATE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd != 4'b0000)); // R3
  AST_GRANT_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_ack) |=> (cmd == 4'b0010 && !ref_req)); // R10
endmodule

bind sdram_init_refresh sdram_init_refresh_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .CAS_LAT(CAS_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd({cs_n, ras_n, cas_n, we_n}), .addr(addr),
  .ba(ba), .init_done(init_done), .ref_req(ref_req), .ref_ack(ref_ack));

// File: tb/sdram_init_refresh_tb.sv
module sdram_init_refresh_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PWRUP = 60;
  localparam int TRP = 5, TRFC = 13, TMRD = 2, NREF = 8, CL = 3;
  localparam int AW = 11, BW = 1, IW = 16;
  localparam int T_PRE0 = PWRUP + 1;
  localparam int T_REF0 = T_PRE0 + TRP;
  localparam int T_MRS  = T_REF0 + NREF * TRFC;
  localparam int T_DONE = T_MRS + TMRD;
  localparam int TARGET_REFS = 30;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0, ref_ack = 1'b0;
  logic [IW-1:0] ref_interval = IW'(TRFC);
  logic cs_n, ras_n, cas_n, we_n, init_done, ref_req;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;

  int n_vec = 0, n_bad = 0, cyc = 0, n_refs = 0;
  int due = 0, exp_pre = -1, exp_ref = -1, ack_wait = -1;
  bit armed = 1'b0, finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_refresh #(.PWRUP_CYC(PWRUP), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
    .INIT_REFS(NREF), .CAS_LAT(CL), .ADDR_W(AW), .BA_W(BW), .IVL_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_interval(ref_interval), .ref_ack(ref_ack),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .init_done(init_done), .ref_req(ref_req));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [3:0] init_cmd(input int c);
    if (c < PWRUP) return 4'b1111;
    if (c == PWRUP) return 4'b0111;
    if (c == T_PRE0) return 4'b0010;
    for (int k = 0; k < NREF; k++) if (c == T_REF0 + k * TRFC) return 4'b0001;
    if (c == T_MRS) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [3:0] cm);
    if (cm == 4'b0010) return AW'(1) << 10;
    if (cm == 4'b0000) return AW'(CL << 4);
    return '0;
  endfunction

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) begin
    logic [3:0] cm, ecm;
    cm = {cs_n, ras_n, cas_n, we_n};
    if (!rst_n) begin
      check(cm == 4'b1111, "R1 cmd", cm, 4'hf);
      check(addr == '0 && ba == '0, "R1 addr/ba", addr, 0);
      check(!init_done && !ref_req, "R1 flags", {init_done, ref_req}, 0);
    end else if (!finished) begin
      if (cyc < T_DONE) begin
        ecm = init_cmd(cyc);
        check(cm == ecm, (cyc <= PWRUP) ? "R2 pwrup" : "R3/R4 init cmd", cm, ecm);
        if (cm == 4'b0010 || cm == 4'b0000)
          check(addr == exp_addr(cm) && ba == '0, "R5/R6 addr", addr, exp_addr(cm));
        check(!init_done, "R7 done early", init_done, 0);
        check(!ref_req, "R8 req early", ref_req, 0);
      end else begin
        if (cyc == T_DONE) begin armed = 1'b1; due = cyc + int'(ref_interval); end
        check(init_done, "R7 done", init_done, 1);
        if (cyc == exp_pre) ecm = 4'b0010;
        else if (cyc == exp_ref) ecm = 4'b0001;
        else ecm = 4'b0111;
        check(cm == ecm, (cyc == exp_ref) ? "R6/R10 refresh" : "R10/R12 cmd", cm, ecm);
        if (cm == 4'b0010)
          check(addr == exp_addr(cm) && ba == '0, "R5 precharge addr", addr, exp_addr(cm));
        if (cyc == exp_ref) begin
          armed = 1'b1; due = cyc + int'(ref_interval); n_refs++;
        end
        check(ref_req == (armed && cyc >= due), "R8/R9/R11 req", ref_req, armed && cyc >= due);
        // grant driver
        if (ref_ack) ref_ack <= 1'b0;
        else if (ref_req) begin
          if (ack_wait < 0) ack_wait = (n_refs < 2) ? 0 : int'($urandom_range(0, 7));
          if (ack_wait == 0) begin
            ref_ack <= 1'b1; armed = 1'b0; exp_pre = cyc + 1; exp_ref = cyc + 1 + TRP;
            ack_wait = -1;
          end else ack_wait--;
        end else if (cyc > exp_ref + TRFC && $urandom_range(0, 9) == 0) begin
          ref_ack <= 1'b1; // stray grant, must be ignored (R12)
        end
        // interval may change at any time; loaded only at refresh issue (R11)
        if (n_refs >= 1 && $urandom_range(0, 3) == 0)
          ref_interval <= IW'($urandom_range(TRFC, 60));
      end
    end
  end

  initial begin
    void'($urandom(32'h5d3a));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (n_refs < TARGET_REFS && cyc < WATCHDOG) @(negedge clk);
    finished = 1'b1;
    if (cyc >= WATCHDOG) check(1'b0, "watchdog R8", n_refs, TARGET_REFS);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule